// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master for serial NOR flash parts. Software places up to 64 bytes in a word-addressed data buffer, programs how many bits to shift, and sets a start bit. The engine then clocks the buffered bits out on MOSI, most significant bit first. When receive capture is enabled, it writes the bits seen on MISO back into the buffer at the same positions. When the last bit is done it clears the start bit and raises a done flag.

The serial clock is built from two 6-bit phase counts, one for the length of a serial clock period and one for its active portion. Chip select can be held asserted after a transfer ends, so one flash command (opcode, address, then a long data stream) can be split across several buffer-sized starts. Clock polarity and chip-select polarity are selectable. Only single-lane operation with data captured on the leading edge is provided, which covers SPI modes 0 and 2.

Top module: `spif_master`

## Requirements
- R1: After reset the command and status registers read zero, `sck` is low and `spi_cs` is high (inactive).
- R2: A write with bit 18 set to offset 0x00, while idle and with status bit 30 clear, starts a transfer. Bit 18 of offset 0x00 reads 1 for as long as the transfer runs and 0 after it.
- R3: The bit count is field value + 1, where the field is bits 25:17 of offset 0x20. Exactly that many serial clock periods are produced.
- R4: MOSI carries the buffer bits most significant bit first. Stream byte k is byte lane k mod 4 (bits 8·(k mod 4)+7 down to 8·(k mod 4)) of the word at 0x40 + 4·(k div 4). The first bit is valid before the first leading edge, and MOSI changes only on trailing edges.
- R5: When bit 0 of offset 0x1C is 1, each MISO bit sampled during the active phase replaces the transmitted bit at the same buffer position. When it is 0, the buffer is left unchanged. Bits beyond the bit count are never touched.
- R6: Bit 4 of offset 0x30 is set by the engine when the last bit ends. Software writes it to clear it.
- R7: Chip select is asserted throughout a transfer. When bit 30 of offset 0x2C is 1 at the end of a transfer, it stays asserted; otherwise it is released as the last bit ends.
- R8: Bit 23 of offset 0x2C set makes chip select active high.
- R9: The idle `sck` level is 1 when bit 7 of offset 0x1C or bit 29 of offset 0x2C is set, and 0 otherwise. The active phase drives the opposite level.
- R10: With L = bits 5:0 and H = bits 11:6 of offset 0x18, one serial period lasts L+1 core cycles, and its first H+1 cycles are active. L = 0 is treated as 1, and H is limited to L−1. A transfer of B bits stays busy for 1 + (B−1)(L+1) + (H+1) cycles.
- R11: While a transfer runs, writes to the buffer and to all registers are ignored, except for the soft reset.
- R12: Writing bit 31 of offset 0x30 resets all registers and the engine in one cycle. The bit reads back 0, and the buffer contents are kept.
- R13: While bit 30 of offset 0x30 is 1, a start request is ignored.
- R14: Offset 0x18 stores an 18-bit field (divider at 17:12, active count at 11:6, period count at 5:0) and reads it back with the upper bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address of the register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sck | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select, polarity programmable |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
On every cycle, the assertions check the following. The phase counter stays within its period. Chip select is held for the whole of a transfer. `sck` sits at its idle level whenever the engine is idle. MOSI moves only on a trailing edge. The done flag follows the final bit. A host buffer write never collides with a capture write. Only the bench's scenarios can show the rest: the exact busy length for each clock setting, the bit order across byte lanes and words, the receive overwrite confined to the programmed bit count, chip select held across two starts, and registers left untouched by writes during a transfer. These are checked by sweeping the divider and the lengths, including a partial final byte and the full 512-bit buffer.

// File: rtl/spif_pkg.sv
package spif_pkg;

  localparam int CNT_W = 6;

  localparam logic [6:0] OFS_CMD   = 7'h00;
  localparam logic [6:0] OFS_CLK   = 7'h18;
  localparam logic [6:0] OFS_USER  = 7'h1C;
  localparam logic [6:0] OFS_USER1 = 7'h20;
  localparam logic [6:0] OFS_USER4 = 7'h2C;
  localparam logic [6:0] OFS_SLAVE = 7'h30;

  localparam int GO_BIT     = 18;
  localparam int LEN_LSB    = 17;
  localparam int RXEN_BIT   = 0;
  localparam int NINV_BIT   = 7;
  localparam int CSHI_BIT   = 23;
  localparam int IDLEHI_BIT = 29;
  localparam int HOLD_BIT   = 30;
  localparam int DONE_BIT   = 4;
  localparam int MODE_BIT   = 30;
  localparam int SRST_BIT   = 31;

  typedef struct packed {
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic             rx_en;
    logic             ninv;
    logic             cs_high;
    logic             idle_high;
    logic             hold;
    logic             slave_mode;
  } ctl_t;

  // period count with the zero case promoted to one
  function automatic logic [CNT_W-1:0] eff_low(input logic [CNT_W-1:0] lo);
    return (lo == '0) ? CNT_W'(1) : lo;
  endfunction

  // active count limited so that every period keeps an idle cycle
  function automatic logic [CNT_W-1:0] eff_high(input logic [CNT_W-1:0] hi,
                                                input logic [CNT_W-1:0] lo_e);
    return (hi >= lo_e) ? lo_e - CNT_W'(1) : hi;
  endfunction

endpackage

// File: rtl/spif_buf.sv
module spif_buf #(
  parameter int WORDS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_we,
  input  logic [$clog2(WORDS)-1:0]          host_widx,
  input  logic [31:0]                       host_wdata,
  input  logic [$clog2(WORDS)-1:0]          host_ridx,
  output logic [31:0]                       host_rdata,
  input  logic [$clog2(WORDS*32)-1:0]       eng_rptr,
  output logic                              eng_rbit,
  input  logic                              eng_we,
  input  logic [$clog2(WORDS*32)-1:0]       eng_wptr,
  input  logic                              eng_wbit
);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BITS_W = $clog2(WORDS * 32);

  // stream index -> storage bit: bytes in ascending lanes, MSB first inside a byte
  function automatic logic [BITS_W-1:0] stream_pos(input logic [BITS_W-1:0] idx);
    return {idx[BITS_W-1:3], ~idx[2:0]};
  endfunction

  logic [WORDS*32-1:0] flat;
  logic [BITS_W-1:0]   wpos;
  assign wpos = stream_pos(eng_wptr);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (host_we && host_widx == WIDX_W'(w)) word_q <= host_wdata;
      else if (eng_we && wpos[BITS_W-1:5] == WIDX_W'(w)) word_q[wpos[4:0]] <= eng_wbit;
    end
    assign flat[w*32 +: 32] = word_q;
  end

  assign host_rdata = flat[host_ridx*32 +: 32];
  assign eng_rbit   = flat[stream_pos(eng_rptr)];

  assert_no_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && eng_we));

endmodule

// File: rtl/spif_sck.sv
module spif_sck import spif_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] hi_raw,
  input  logic [CNT_W-1:0] lo_raw,
  output logic             lead_evt,
  output logic             trail_evt,
  output logic             sck_active
);
  logic [CNT_W-1:0] cnt_q, lo_e, hi_e;

  assign lo_e = eff_low(lo_raw);
  assign hi_e = eff_high(hi_raw, lo_e);

  // load parks the counter at the period end: one idle setup cycle precedes bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (load) cnt_q <= lo_e;
    else if (run)  cnt_q <= (cnt_q == lo_e) ? '0 : cnt_q + CNT_W'(1);
  end

  assign lead_evt   = run && cnt_q == '0;
  assign trail_evt  = run && cnt_q == hi_e;
  assign sck_active = run && cnt_q <= hi_e;

  assert_cnt_in_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= lo_e);
  assert_setup_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> !sck_active);

endmodule

// File: rtl/spif_regs.sv
module spif_regs import spif_pkg::*; #(
  parameter int LEN_W  = 9,
  parameter int WIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              end_evt,
  input  logic [31:0]       buf_rdata,
  output logic              buf_we,
  output logic [WIDX_W-1:0] buf_widx,
  output logic [WIDX_W-1:0] buf_ridx,
  output logic              start,
  output logic              soft_rst,
  output ctl_t              ctl,
  output logic [LEN_W-1:0]  len
);
  ctl_t             ctl_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic             wr_ok;

  assign wr_ok    = wr_en && !busy;
  assign soft_rst = wr_en && addr == OFS_SLAVE && wdata[SRST_BIT];
  assign start    = wr_ok && addr == OFS_CMD && wdata[GO_BIT] && !ctl_q.slave_mode;
  assign buf_we   = wr_ok && addr[6];
  assign buf_widx = addr[WIDX_W+1:2];
  assign buf_ridx = addr[WIDX_W+1:2];
  assign ctl      = ctl_q;
  assign len      = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; len_q <= '0; done_q <= 1'b0;
    end else if (soft_rst) begin
      ctl_q <= '0; len_q <= '0; done_q <= 1'b0;
    end else begin
      if (end_evt)                          done_q <= 1'b1;
      else if (wr_ok && addr == OFS_SLAVE)  done_q <= wdata[DONE_BIT];
      if (wr_ok) begin
        case (addr)
          OFS_CLK: begin
            ctl_q.div <= wdata[17:12];
            ctl_q.hi  <= wdata[11:6];
            ctl_q.lo  <= wdata[5:0];
          end
          OFS_USER: begin
            ctl_q.rx_en <= wdata[RXEN_BIT];
            ctl_q.ninv  <= wdata[NINV_BIT];
          end
          OFS_USER1: len_q <= wdata[LEN_LSB +: LEN_W];
          OFS_USER4: begin
            ctl_q.cs_high   <= wdata[CSHI_BIT];
            ctl_q.idle_high <= wdata[IDLEHI_BIT];
            ctl_q.hold      <= wdata[HOLD_BIT];
          end
          OFS_SLAVE: ctl_q.slave_mode <= wdata[MODE_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CMD:   rdata[GO_BIT] = busy;
      OFS_CLK:   rdata[17:0] = {ctl_q.div, ctl_q.hi, ctl_q.lo};
      OFS_USER:  begin rdata[RXEN_BIT] = ctl_q.rx_en; rdata[NINV_BIT] = ctl_q.ninv; end
      OFS_USER1: rdata[LEN_LSB +: LEN_W] = len_q;
      OFS_USER4: begin
        rdata[CSHI_BIT]   = ctl_q.cs_high;
        rdata[IDLEHI_BIT] = ctl_q.idle_high;
        rdata[HOLD_BIT]   = ctl_q.hold;
      end
      OFS_SLAVE: begin rdata[MODE_BIT] = ctl_q.slave_mode; rdata[DONE_BIT] = done_q; end
      default:   if (addr[6]) rdata = buf_rdata;
    endcase
  end

  assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !soft_rst) |=> done_q);
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !soft_rst && !$past(soft_rst)) |-> $stable(len_q));

endmodule

// File: rtl/spif_master.sv
module spif_master import spif_pkg::*; #(
  parameter int BUF_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sck,
  output logic        spi_cs,
  output logic        mosi,
  input  logic        miso
);
  localparam int BUF_BITS = BUF_WORDS * 32;
  localparam int LEN_W    = $clog2(BUF_BITS);
  localparam int WIDX_W   = $clog2(BUF_WORDS);

  ctl_t              ctl;
  logic [LEN_W-1:0]  len;
  logic              start, soft_rst, buf_we;
  logic [WIDX_W-1:0] buf_widx, buf_ridx;
  logic [31:0]       buf_rdata;
  logic              lead_evt, trail_evt, sck_active, end_evt;
  logic              busy_q, cs_act_q, mosi_q;
  logic [LEN_W-1:0]  idx_q, rptr;
  logic              rbit, cpol_eff;

  spif_regs #(.LEN_W(LEN_W), .WIDX_W(WIDX_W)) u_regs (
    .clk, .rst_n, .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy_q), .end_evt, .buf_rdata, .buf_we,
    .buf_widx, .buf_ridx, .start, .soft_rst, .ctl, .len
  );

  spif_sck u_sck (
    .clk, .rst_n, .clr(soft_rst), .load(start), .run(busy_q),
    .hi_raw(ctl.hi), .lo_raw(ctl.lo), .lead_evt, .trail_evt, .sck_active
  );

  spif_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk, .rst_n, .host_we(buf_we), .host_widx(buf_widx), .host_wdata(reg_wdata),
    .host_ridx(buf_ridx), .host_rdata(buf_rdata), .eng_rptr(rptr), .eng_rbit(rbit),
    .eng_we(busy_q && lead_evt && ctl.rx_en), .eng_wptr(idx_q), .eng_wbit(miso)
  );

  assign end_evt  = busy_q && trail_evt && idx_q == len;
  assign rptr     = busy_q ? idx_q + LEN_W'(1) : '0;
  assign cpol_eff = ctl.ninv | ctl.idle_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cs_act_q <= 1'b0; mosi_q <= 1'b0; idx_q <= '0;
    end else if (soft_rst) begin
      busy_q <= 1'b0; cs_act_q <= 1'b0; mosi_q <= 1'b0; idx_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1; cs_act_q <= 1'b1; idx_q <= '0; mosi_q <= rbit;
    end else if (end_evt) begin
      busy_q <= 1'b0; cs_act_q <= ctl.hold;
    end else if (busy_q && trail_evt) begin
      idx_q <= idx_q + LEN_W'(1); mosi_q <= rbit;
    end
  end

  assign sck    = cpol_eff ^ sck_active;
  assign spi_cs = ctl.cs_high ? cs_act_q : ~cs_act_q;
  assign mosi   = mosi_q;

  assert_cs_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cs_act_q);
  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck == cpol_eff);
  assert_mosi_on_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(trail_evt)) |-> $stable(mosi));
  assert_end_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !soft_rst) |=> !busy_q);

endmodule

// File: tb/sim_spif_master.sv
module sim_spif_master;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, miso = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         sck, spi_cs, mosi;

  always #10 clk = ~clk;

  spif_master u0 (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
                  .sck, .spi_cs, .mosi, .miso);

  localparam logic [6:0] A_CMD = 7'h00, A_CLK = 7'h18, A_USER = 7'h1C,
                         A_USER1 = 7'h20, A_USER4 = 7'h2C, A_SLAVE = 7'h30, A_BUF = 7'h40;

  int checks = 0, errors = 0;
  int lead_cnt = 0, trail_cnt = 0, sseed = 0;
  logic prev_sck = 1'b0, idle_lvl = 1'b0;
  logic [511:0] cap = '0;

  function automatic logic [7:0] tbyte(int b, int seed);
    return 8'(b * 11 + seed * 7 + 3);
  endfunction
  function automatic logic sbit(int k, int seed);
    logic [7:0] b;
    b = 8'((k / 8) * 37 + seed);
    return b[7 - k % 8];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // called right after the start write; counts cycles with the start bit readable as 1
  task automatic count_busy(output int cyc, output logic cs_first);
    cyc = 0; cs_first = spi_cs;
    reg_addr = A_CMD;
    forever begin
      #1;
      if (!reg_rdata[18] || cyc > 100000) break;
      if (cyc == 0) cs_first = spi_cs;
      cyc++;
      @(negedge clk);
    end
  endtask

  // slave model: capture MOSI on leading edges, advance MISO after trailing edges
  initial forever begin
    @(negedge clk); #2;
    if (sck !== prev_sck) begin
      if (sck !== idle_lvl) begin
        if (lead_cnt < 512) cap[lead_cnt] = mosi;
        lead_cnt++;
      end else trail_cnt++;
      prev_sck = sck;
    end
    miso = sbit(trail_cnt, sseed);
  end

  task automatic run_xfer(int nbits, bit rxen, bit hold, bit cpol, int n, int seed);
    int lo, hi, cyc, exp_cyc, bad;
    logic cs_first;
    logic [31:0] d, e;
    lo = n; hi = (n + 1) / 2 - 1;
    for (int w = 0; w < 16; w++)
      wr(A_BUF + 7'(4 * w), {tbyte(4*w+3, seed), tbyte(4*w+2, seed), tbyte(4*w+1, seed), tbyte(4*w, seed)});
    wr(A_CLK, (n << 12) | (hi << 6) | lo);
    wr(A_USER, 32'(rxen) | (32'(cpol) << 7));
    wr(A_USER1, (nbits - 1) << 17);
    wr(A_USER4, 32'(hold) << 30);
    wr(A_SLAVE, 32'h0);
    @(negedge clk);
    idle_lvl = cpol; prev_sck = sck; lead_cnt = 0; trail_cnt = 0; sseed = seed;
    miso = sbit(0, seed); cap = '0;
    check("R9 idle sck level", 32'(sck), 32'(cpol));
    wr(A_CMD, 32'h1 << 18);
    count_busy(cyc, cs_first);
    exp_cyc = 1 + (nbits - 1) * (lo + 1) + hi + 1;
    check("R10 busy cycles", cyc, exp_cyc);
    check("R7 cs asserted during transfer", 32'(cs_first), 32'h0);
    check("R3 serial periods", lead_cnt, nbits);
    bad = 0;
    for (int j = 0; j < nbits; j++) begin
      logic [7:0] tb;
      tb = tbyte(j / 8, seed);
      if (cap[j] !== tb[7 - j % 8]) bad++;
    end
    check("R4 mosi bit order", bad, 0);
    rd(A_SLAVE, d);
    check("R6 done set", d, 32'h10);
    rd(A_CMD, d);
    check("R2 start bit cleared", d, 32'h0);
    check("R7 cs after end", 32'(spi_cs), hold ? 32'h0 : 32'h1);
    check("R9 sck back to idle", 32'(sck), 32'(cpol));
    for (int w = 0; w < 16; w++) begin
      for (int b = 0; b < 32; b++) begin
        int by, j;
        logic [7:0] tb;
        by = 4 * w + b / 8;
        j = by * 8 + 7 - b % 8;
        tb = tbyte(by, seed);
        e[b] = (rxen && j < nbits) ? sbit(j, seed) : tb[b % 8];
      end
      rd(A_BUF + 7'(4 * w), d);
      check("R5 buffer after transfer", d, e);
    end
    wr(A_SLAVE, 32'h0);
    rd(A_SLAVE, d);
    check("R6 done cleared by write", d, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cyc;
    logic csf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_CMD, d);   check("R1 command after reset", d, 32'h0);
    rd(A_SLAVE, d); check("R1 status after reset", d, 32'h0);
    check("R1 cs after reset", 32'(spi_cs), 32'h1);
    check("R1 sck after reset", 32'(sck), 32'h0);

    wr(A_CLK, 32'hFFFF_FFFF);
    rd(A_CLK, d); check("R14 clock field readback", d, 32'h0003_FFFF);

    for (int n = 1; n <= 4; n++) run_xfer(8, 1'b1, 1'b0, 1'b0, n, n);
    run_xfer(13, 1'b1, 1'b0, 1'b1, 3, 5);
    run_xfer(16, 1'b0, 1'b0, 1'b0, 2, 9);
    run_xfer(512, 1'b1, 1'b1, 1'b0, 1, 11);
    run_xfer(24, 1'b1, 1'b0, 1'b0, 2, 12);

    // R8 active-high chip select
    wr(A_USER4, 32'h1 << 23);
    check("R8 cs idle with high polarity", 32'(spi_cs), 32'h0);
    wr(A_CMD, 32'h1 << 18);
    count_busy(cyc, csf);
    check("R8 cs active high during transfer", 32'(csf), 32'h1);
    check("R8 cs released low", 32'(spi_cs), 32'h0);
    wr(A_USER4, 32'h0);

    // R11 writes during a transfer are ignored
    wr(A_BUF + 7'd20, 32'h1234_5678);
    wr(A_CLK, (20 << 12) | (9 << 6) | 20);
    wr(A_USER1, 7 << 17);
    wr(A_CMD, 32'h1 << 18);
    wr(A_BUF + 7'd20, 32'hDEAD_BEEF);
    wr(A_USER1, 32'h0);
    wr(A_CLK, 32'h0);
    rd(A_CMD, d); check("R11 start bit still set mid transfer", d, 32'h1 << 18);
    wr(A_CMD, 32'h0);
    count_busy(cyc, csf);
    rd(A_BUF + 7'd20, d); check("R11 buffer write ignored", d, 32'h1234_5678);
    rd(A_USER1, d);       check("R11 length write ignored", d, 32'h7 << 17);
    rd(A_CLK, d);         check("R11 clock write ignored", d, (20 << 12) | (9 << 6) | 20);

    // R13 start blocked outside master mode
    wr(A_SLAVE, 32'h1 << 30);
    wr(A_CMD, 32'h1 << 18);
    rd(A_CMD, d);   check("R13 start ignored", d, 32'h0);
    check("R13 cs stays idle", 32'(spi_cs), 32'h1);
    rd(A_SLAVE, d); check("R13 mode bit stored", d, 32'h4000_0000);

    // R12 soft reset
    wr(A_SLAVE, 32'h8000_0000);
    rd(A_SLAVE, d);       check("R12 soft reset self clears", d, 32'h0);
    rd(A_CLK, d);         check("R12 clock register reset", d, 32'h0);
    rd(A_USER1, d);       check("R12 length reset", d, 32'h0);
    rd(A_BUF + 7'd20, d); check("R12 buffer kept", d, 32'h1234_5678);

    // R10 clamp: zero counts behave as period 2, active 1
    wr(A_USER1, 3 << 17);
    wr(A_CMD, 32'h1 << 18);
    count_busy(cyc, csf);
    check("R10 clamped timing", cyc, 8);

    finish_run();
  end
endmodule